// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with APB Register Access

The block is an APB slave that drives four independent pulse-width outputs. Every channel repeats a period made of a high phase followed by a low phase. Software sets the length of each phase in counting ticks. Each channel chooses its own tick source. The source is either every APB clock cycle or each rising edge of a slower external clock, which is first resynchronised into the APB domain.

Software writes the tick counts directly. The work of turning a time request into tick counts, and of picking the source that fits the request, stays in software. A polarity bit per channel swaps the levels of the two phases. A single enable register starts and stops the channels. New phase lengths written while a channel runs wait for the current period to end before they apply. Disabling a channel stops it at once and forces its output low.

Top module: `quad_pwm_apb`

## Requirements
- R1: After reset every register reads 0, all channels are stopped and every `pwm_out` bit is 0.
- R2: Register map with a 0x10 stride per channel n (0..3). The enable register is at 0x1C and bit 3+4n enables channel n; all other bits of it read 0. The control register is at 0x20+0x10n, and only bits [4:0] are stored. Bit 2 of the control register is the PWM mode bit and bit 3 is the source select, where 1 means the APB clock and 0 means the external clock. Bit 4 inverts the polarity. The reload register is at 0x24+0x10n, with the high length minus one in bits [31:16] and the low length minus one in bits [15:0]. The counter register is at 0x28+0x10n and is read-only.
- R3: A running channel begins in the high phase when it is enabled. The high phase lasts (high field + 1) ticks and the low phase lasts (low field + 1) ticks, and the two phases then alternate. A field of 0 gives a phase of one tick, so the duty is never 0% or 100%.
- R4: When a channel is enabled, its counter register is loaded with the high field. The counter then counts down by one on each tick.
- R5: When the polarity bit is set, the high phase drives 0 and the low phase drives 1.
- R6: When a channel's enable bit is cleared, the channel stops in the next cycle. The period in progress is dropped, the output goes to 0 and the counter reads 0.
- R7: With the APB source selected, every APB clock cycle is one tick. With the external source selected, each rising edge of `ext_clk`, seen after a two-flop synchronizer, is one tick.
- R8: A reload write to a running channel leaves the current period unchanged. The new lengths apply from the next period onward.
- R9: After the source of a running channel is changed and the reload register is then written, the channel's periods follow the new source and the new lengths.
- R10: Reads at offsets outside the map return 0, and writes to them change no register and no output.
- R11: A channel whose mode bit is 0 stays stopped and outputs 0, even when its enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock; all logic runs on it |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1, read when 0 |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid while selected for a read |
| ext_clk | input | 1 | Slow external counting clock, asynchronous |
| pwm_out | output | 4 | One waveform output per channel |

## Verification
The bench builds the block with its default parameters: four channels, 16-bit phase fields, an 8-bit address and a two-stage synchronizer. With these values every register offset and enable bit position in the map is reached. The shortest setting, one tick per phase, can be checked, and the largest field value can be read back from the counter while the external source is idle. The external clock runs at one sixth of the APB rate, so each external tick spans exactly six APB cycles. That makes the phase lengths on that source exact, and a change of source while a channel runs can be observed.

// File: rtl/qpwm_pkg.sv
package qpwm_pkg;
  localparam int ENA_OFS       = 'h1C;
  localparam int CH_BASE       = 'h20;
  localparam int CH_STRIDE     = 'h10;
  localparam int CTL_OFS       = 'h0;
  localparam int RLD_OFS       = 'h4;
  localparam int CNT_OFS       = 'h8;
  localparam int EN_BIT_BASE   = 3;
  localparam int EN_BIT_STRIDE = 4;
  localparam int CTL_W         = 5;
  localparam int CTL_MODE      = 2;
  localparam int CTL_SRC       = 3;
  localparam int CTL_PARK      = 4;
  localparam int HI_LSB        = 16;

  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_e;
endpackage

// File: rtl/qpwm_ext_tick.sv
module qpwm_ext_tick #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  output logic tick
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], ext_clk};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign tick = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/qpwm_regs.sv
module qpwm_regs
  import qpwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      psel,
  input  logic                      penable,
  input  logic                      pwrite,
  input  logic [ADDR_W-1:0]         paddr,
  input  logic [DATA_W-1:0]         pwdata,
  output logic [DATA_W-1:0]         prdata,
  input  logic [NUM_CH*CNT_W-1:0]   cnt_flat,
  output logic [NUM_CH-1:0]         en_o,
  output logic [NUM_CH*CTL_W-1:0]   ctrl_flat,
  output logic [NUM_CH*CNT_W-1:0]   rl_hi_flat,
  output logic [NUM_CH*CNT_W-1:0]   rl_lo_flat
);
  logic              wr_en;
  logic [NUM_CH-1:0] en_q, en_d;
  logic [CTL_W-1:0]  ctrl_q [NUM_CH];
  logic [CTL_W-1:0]  ctrl_d [NUM_CH];
  logic [CNT_W-1:0]  hi_q   [NUM_CH];
  logic [CNT_W-1:0]  hi_d   [NUM_CH];
  logic [CNT_W-1:0]  lo_q   [NUM_CH];
  logic [CNT_W-1:0]  lo_d   [NUM_CH];
  logic [DATA_W-1:0] rdata;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign wr_en = psel & penable & pwrite;

  always_comb begin
    en_d  = en_q;
    rdata = '0;
    if (hit(paddr, ENA_OFS)) begin
      for (int c = 0; c < NUM_CH; c++) begin
        rdata[EN_BIT_BASE + EN_BIT_STRIDE*c] = en_q[c];
        if (wr_en) en_d[c] = pwdata[EN_BIT_BASE + EN_BIT_STRIDE*c];
      end
    end
    for (int c = 0; c < NUM_CH; c++) begin
      ctrl_d[c] = ctrl_q[c];
      hi_d[c]   = hi_q[c];
      lo_d[c]   = lo_q[c];
      if (hit(paddr, CH_BASE + CH_STRIDE*c + CTL_OFS)) begin
        rdata[CTL_W-1:0] = ctrl_q[c];
        if (wr_en) ctrl_d[c] = pwdata[CTL_W-1:0];
      end
      if (hit(paddr, CH_BASE + CH_STRIDE*c + RLD_OFS)) begin
        rdata[HI_LSB +: CNT_W] = hi_q[c];
        rdata[0 +: CNT_W]      = lo_q[c];
        if (wr_en) begin
          hi_d[c] = pwdata[HI_LSB +: CNT_W];
          lo_d[c] = pwdata[0 +: CNT_W];
        end
      end
      if (hit(paddr, CH_BASE + CH_STRIDE*c + CNT_OFS)) begin
        rdata[0 +: CNT_W] = cnt_flat[c*CNT_W +: CNT_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      for (int c = 0; c < NUM_CH; c++) begin
        ctrl_q[c] <= '0;
        hi_q[c]   <= '0;
        lo_q[c]   <= '0;
      end
    end else begin
      en_q <= en_d;
      for (int c = 0; c < NUM_CH; c++) begin
        ctrl_q[c] <= ctrl_d[c];
        hi_q[c]   <= hi_d[c];
        lo_q[c]   <= lo_d[c];
      end
    end
  end

  assign prdata = (psel && !pwrite) ? rdata : '0;
  assign en_o   = en_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_flat
    assign ctrl_flat[c*CTL_W +: CTL_W]  = ctrl_q[c];
    assign rl_hi_flat[c*CNT_W +: CNT_W] = hi_q[c];
    assign rl_lo_flat[c*CNT_W +: CNT_W] = lo_q[c];
  end
endmodule

// File: rtl/qpwm_channel.sv
module qpwm_channel
  import qpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             tick,
  input  logic             park,
  input  logic [CNT_W-1:0] rl_hi,
  input  logic [CNT_W-1:0] rl_lo,
  output logic             pwm,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             phase_o,
  output logic [CNT_W-1:0] act_hi_o
);
  logic             run_q, run_d;
  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] ahi_q, ahi_d;
  logic [CNT_W-1:0] alo_q, alo_d;

  always_comb begin
    run_d   = run_q;
    phase_d = phase_q;
    cnt_d   = cnt_q;
    ahi_d   = ahi_q;
    alo_d   = alo_q;
    if (!go) begin
      run_d   = 1'b0;
      phase_d = PH_HIGH;
      cnt_d   = '0;
    end else if (!run_q) begin
      run_d   = 1'b1;
      phase_d = PH_HIGH;
      cnt_d   = rl_hi;
      ahi_d   = rl_hi;
      alo_d   = rl_lo;
    end else if (tick) begin
      if (cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end else if (phase_q == PH_HIGH) begin
        phase_d = PH_LOW;
        cnt_d   = alo_q;
      end else begin
        phase_d = PH_HIGH;
        cnt_d   = rl_hi;
        ahi_d   = rl_hi;
        alo_d   = rl_lo;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      phase_q <= PH_HIGH;
      cnt_q   <= '0;
      ahi_q   <= '0;
      alo_q   <= '0;
    end else begin
      run_q   <= run_d;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      ahi_q   <= ahi_d;
      alo_q   <= alo_d;
    end
  end

  assign pwm      = run_q & (phase_q ^ park);
  assign cnt_o    = cnt_q;
  assign run_o    = run_q;
  assign phase_o  = phase_q;
  assign act_hi_o = ahi_q;
endmodule

// File: rtl/quad_pwm_apb.sv
module quad_pwm_apb
  import qpwm_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic              ext_clk,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [NUM_CH-1:0]       en_vec;
  logic [NUM_CH-1:0]       go_vec;
  logic [NUM_CH-1:0]       tick_vec;
  logic [NUM_CH-1:0]       run_vec;
  logic [NUM_CH-1:0]       phase_vec;
  logic [NUM_CH*CTL_W-1:0] ctrl_flat;
  logic [NUM_CH*CNT_W-1:0] rl_hi_flat;
  logic [NUM_CH*CNT_W-1:0] rl_lo_flat;
  logic [NUM_CH*CNT_W-1:0] cnt_flat;
  logic [NUM_CH*CNT_W-1:0] act_hi_flat;
  logic                    ext_tick;

  qpwm_regs #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(32)
  ) u_regs (
    .clk(pclk), .rst_n(presetn),
    .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .cnt_flat(cnt_flat), .en_o(en_vec), .ctrl_flat(ctrl_flat),
    .rl_hi_flat(rl_hi_flat), .rl_lo_flat(rl_lo_flat)
  );

  qpwm_ext_tick #(.STAGES(SYNC_STAGES)) u_ext (
    .clk(pclk), .rst_n(presetn), .ext_clk(ext_clk), .tick(ext_tick)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [CTL_W-1:0] ctl;
    assign ctl         = ctrl_flat[c*CTL_W +: CTL_W];
    assign go_vec[c]   = en_vec[c] & ctl[CTL_MODE];
    assign tick_vec[c] = ctl[CTL_SRC] ? 1'b1 : ext_tick;

    qpwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(pclk), .rst_n(presetn),
      .go(go_vec[c]), .tick(tick_vec[c]), .park(ctl[CTL_PARK]),
      .rl_hi(rl_hi_flat[c*CNT_W +: CNT_W]),
      .rl_lo(rl_lo_flat[c*CNT_W +: CNT_W]),
      .pwm(pwm_out[c]),
      .cnt_o(cnt_flat[c*CNT_W +: CNT_W]),
      .run_o(run_vec[c]), .phase_o(phase_vec[c]),
      .act_hi_o(act_hi_flat[c*CNT_W +: CNT_W])
    );
  end
endmodule

// File: rtl/qpwm_chk.sv
module qpwm_chk #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_CH-1:0]       pwm_out,
  input logic [NUM_CH-1:0]       go_vec,
  input logic [NUM_CH-1:0]       run_vec,
  input logic [NUM_CH-1:0]       phase_vec,
  input logic [NUM_CH-1:0]       tick_vec,
  input logic [NUM_CH*CNT_W-1:0] cnt_flat,
  input logic [NUM_CH*CNT_W-1:0] act_hi_flat,
  input logic                    ext_tick
);
  always @(posedge clk) begin
    if (rst_n === 1'b0) begin
      // R1
      reset_quiet_chk: assert (pwm_out == '0);
    end
  end

  // R7
  single_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_tick |=> !ext_tick);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    // R6
    stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !go_vec[c] |=> !pwm_out[c]);
    // R3
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_vec[c] && go_vec[c] && tick_vec[c] && cnt_flat[c*CNT_W +: CNT_W] != '0)
      |=> $stable(phase_vec[c]));
    // R8
    reload_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_vec[c] && !(tick_vec[c] && !phase_vec[c] && cnt_flat[c*CNT_W +: CNT_W] == '0))
      |=> $stable(act_hi_flat[c*CNT_W +: CNT_W]));
    // R4
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go_vec[c] && !run_vec[c]) |=> (run_vec[c] && phase_vec[c]));
  end
endmodule

bind quad_pwm_apb qpwm_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(pclk), .rst_n(presetn), .pwm_out(pwm_out), .go_vec(go_vec),
  .run_vec(run_vec), .phase_vec(phase_vec), .tick_vec(tick_vec),
  .cnt_flat(cnt_flat), .act_hi_flat(act_hi_flat), .ext_tick(ext_tick)
);

// File: tb/quad_pwm_apb_tb.sv
module quad_pwm_apb_tb;
  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        ext_clk = 1'b0;
  logic        ext_run = 1'b0;
  logic [3:0]  pwm_out;

  int vectors = 0, errors = 0;
  int hist_len [4][32];
  logic hist_lvl [4][32];
  int hist_n [4];
  int cur_len [4];
  logic cur_lvl [4];
  int clr_seq = 0, seen_seq = 0, ediv = 0;

  always #4 pclk = ~pclk;

  quad_pwm_apb u_dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .ext_clk(ext_clk), .pwm_out(pwm_out)
  );

  always @(negedge pclk) begin
    if (ext_run) begin
      ediv = ediv + 1;
      if (ediv == 3) begin
        ediv = 0;
        ext_clk <= ~ext_clk;
      end
    end
  end

  always @(negedge pclk) begin
    if (clr_seq != seen_seq) begin
      seen_seq = clr_seq;
      for (int c = 0; c < 4; c++) begin
        hist_n[c] = 0; cur_len[c] = 1; cur_lvl[c] = pwm_out[c];
      end
    end else begin
      for (int c = 0; c < 4; c++) begin
        if (pwm_out[c] === cur_lvl[c]) cur_len[c]++;
        else begin
          if (hist_n[c] < 32) begin
            hist_len[c][hist_n[c]] = cur_len[c];
            hist_lvl[c][hist_n[c]] = cur_lvl[c];
          end
          hist_n[c]++;
          cur_lvl[c] = pwm_out[c];
          cur_len[c] = 1;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge pclk); penable = 1; d = prdata;
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  task automatic clear_hist();
    clr_seq++;
    repeat (2) @(negedge pclk);
  endtask

  task automatic quiesce();
    apb_wr(8'h1C, 0);
    repeat (3) @(negedge pclk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 outputs", {28'h0, pwm_out}, 0);
    apb_rd(8'h1C, d); chk("R1 enable reg", d, 0);
    apb_rd(8'h20, d); chk("R1 ctrl0", d, 0);
    apb_rd(8'h34, d); chk("R1 reload1", d, 0);
    apb_rd(8'h58, d); chk("R1 counter3", d, 0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    apb_wr(8'h1C, 32'hFFFF_FFFF);
    apb_rd(8'h1C, d); chk("R2 enable bits", d, 32'h0000_8888);
    apb_wr(8'h1C, 0);
    apb_wr(8'h40, 32'hFFFF_FFFF);
    apb_rd(8'h40, d); chk("R2 ctrl width", d, 32'h1F);
    apb_wr(8'h40, 0);
    apb_wr(8'h44, 32'hABCD_1234);
    apb_rd(8'h44, d); chk("R2 reload fields", d, 32'hABCD_1234);
    apb_wr(8'h48, 32'h5555);
    apb_rd(8'h48, d); chk("R2 counter read-only", d, 0);
  endtask

  task automatic t_apb_wave(input int hi, input int lo, input bit park);
    clear_hist();
    apb_wr(8'h20, park ? 32'h1C : 32'h0C);
    apb_wr(8'h24, (hi << 16) | lo);
    apb_wr(8'h1C, 32'h8);
    repeat (4 * (hi + lo + 2) + 10) @(negedge pclk);
    quiesce();
    if (!park) begin
      chk("R3 first high", hist_len[0][1], hi + 1);
      chk("R3 low", hist_len[0][2], lo + 1);
      chk("R3 second high", hist_len[0][3], hi + 1);
      chk("R3 level order", {31'h0, hist_lvl[0][1]}, 1);
    end else begin
      chk("R5 inverted low-phase high", hist_len[0][1], lo + 1);
      chk("R5 inverted high-phase low", hist_len[0][2], hi + 1);
    end
    apb_wr(8'h20, 0);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    apb_wr(8'h20, 32'h0C);
    apb_wr(8'h24, (50 << 16) | 50);
    apb_wr(8'h1C, 32'h8);
    repeat (10) @(negedge pclk);
    apb_wr(8'h1C, 0);
    @(negedge pclk);
    chk("R6 output forced low", {31'h0, pwm_out[0]}, 0);
    apb_rd(8'h28, d); chk("R6 counter cleared", d, 0);
    apb_wr(8'h20, 0);
  endtask

  task automatic t_reload_defer();
    clear_hist();
    apb_wr(8'h30, 32'h0C);
    apb_wr(8'h34, (9 << 16) | 9);
    apb_wr(8'h1C, 32'h80);
    apb_wr(8'h34, (1 << 16) | 2);
    repeat (40) @(negedge pclk);
    quiesce();
    chk("R8 current high kept", hist_len[1][1], 10);
    chk("R8 current low kept", hist_len[1][2], 10);
    chk("R8 new high", hist_len[1][3], 2);
    chk("R8 new low", hist_len[1][4], 3);
    apb_wr(8'h30, 0);
  endtask

  task automatic t_ext_and_switch();
    int e1, e2;
    ext_run = 1;
    clear_hist();
    apb_wr(8'h30, 32'h04);
    apb_wr(8'h34, (1 << 16) | 2);
    apb_wr(8'h1C, 32'h80);
    repeat (100) @(negedge pclk);
    chk("R7 ext low length", hist_len[1][2], 18);
    chk("R7 ext high length", hist_len[1][3], 12);
    apb_wr(8'h30, 32'h0C);
    apb_wr(8'h34, (3 << 16) | 1);
    repeat (100) @(negedge pclk);
    clear_hist();
    repeat (30) @(negedge pclk);
    e1 = hist_lvl[1][1] ? 4 : 2;
    e2 = hist_lvl[1][2] ? 4 : 2;
    chk("R9 new source run A", hist_len[1][1], e1);
    chk("R9 new source run B", hist_len[1][2], e2);
    quiesce();
    ext_run = 0;
    apb_wr(8'h30, 0);
  endtask

  task automatic t_counter();
    logic [31:0] d;
    repeat (10) @(negedge pclk);
    apb_wr(8'h20, 32'h04);
    apb_wr(8'h24, 32'hFFFF_0005);
    apb_wr(8'h1C, 32'h8);
    repeat (5) @(negedge pclk);
    apb_rd(8'h28, d); chk("R4 counter holds high field", d, 32'hFFFF);
    quiesce();
    apb_wr(8'h20, 0);
  endtask

  task automatic t_unmapped_and_mode();
    logic [31:0] d;
    clear_hist();
    apb_wr(8'h00, 32'hFFFF_FFFF);
    apb_wr(8'h18, 32'hFFFF_FFFF);
    apb_wr(8'h2C, 32'hFFFF_FFFF);
    apb_rd(8'h00, d); chk("R10 unmapped 0x00 reads 0", d, 0);
    apb_rd(8'h2C, d); chk("R10 unmapped 0x2C reads 0", d, 0);
    apb_rd(8'h1C, d); chk("R10 enable untouched", d, 0);
    apb_rd(8'h20, d); chk("R10 ctrl0 untouched", d, 0);
    apb_wr(8'h50, 32'h08);
    apb_wr(8'h54, 0);
    apb_wr(8'h1C, 32'h8000);
    repeat (20) @(negedge pclk);
    chk("R11 mode off output", {28'h0, pwm_out}, 0);
    chk("R11 mode off no toggles", hist_n[3], 0);
    quiesce();
    apb_wr(8'h50, 0);
  endtask

  task automatic t_min_and_select();
    clear_hist();
    apb_wr(8'h40, 32'h0C);
    apb_wr(8'h44, 0);
    apb_wr(8'h1C, 32'h800);
    repeat (12) @(negedge pclk);
    quiesce();
    chk("R3 min high one tick", hist_len[2][1], 1);
    chk("R3 min low one tick", hist_len[2][2], 1);
    chk("R2 bit 11 drives channel 2 only", hist_n[0] + hist_n[1] + hist_n[3], 0);
    apb_wr(8'h40, 0);
  endtask

  initial begin
    repeat (150000) @(posedge pclk);
    vectors++; errors++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge pclk);
    presetn = 1'b1;
    repeat (2) @(negedge pclk);
    t_reset();
    t_map();
    t_apb_wave(2, 4, 0);
    t_apb_wave(2, 4, 1);
    t_min_and_select();
    t_disable();
    t_reload_defer();
    t_ext_and_switch();
    t_counter();
    t_unmapped_and_mode();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule